// File: doc/BRIEF.md
# Parity-Protected Write-Through Cache with Spare Bank

This block is a direct-mapped data cache placed between a processor request port and a main-memory port. Every store is forwarded to memory, so memory always holds a correct copy of every cached word. Each stored data byte carries an even-parity bit. The tag and valid bits of each line share one more parity bit. Parity is generated whenever a line is filled or a write hit updates it.

When a lookup finds bad parity, no bad data is ever returned. The line is invalidated, the access becomes a miss, and the word is read again from memory. An error that does not come back is invisible to the requester. Each detected error adds one to a saturating counter. When the counter reaches a programmable threshold, a second storage bank takes over from the failing one while requests keep being served. At the switch every line in the new bank is marked invalid, so the new bank fills only from memory. Software can read the counter and the spare flag, and can clear the counter. A fault-injection port flips single stored bits in the active bank so that error handling can be exercised.

Top module: `pc_cache`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, mem_req, spare_on and err_count are all 0.
- R2: A read miss issues exactly one memory read, returns the memory word and fills the line. A repeated read of the same address then returns the same word with no memory access. The line index is address bits [IDX_W-1:0] and the tag is the remaining upper bits.
- R3: Every write issues exactly one memory write of the given word with mem_we=1. A write hit also updates the cached word. A write miss allocates nothing, so a later read of that address misses.
- R4: A read hit whose data bytes and byte-parity bits disagree under even parity returns the correct word from memory through one memory read and adds 1 to err_count. After the refill, the next read of that address hits and adds nothing.
- R5: A tag-entry parity error on an access invalidates the line and adds 1 to err_count. On a read the word is then fetched from memory and returned correctly.
- R6: When err_count reaches a nonzero thresh, spare_on rises in that same cycle and stays at 1. From then on every line reads as invalid. With thresh set to 0 the spare bank is never selected.
- R7: clr_cnt=1 sets err_count to 0 on the next edge, and this takes priority over an increment in the same cycle.
- R8: err_count saturates at its all-ones value and never wraps.
- R9: Only one request is in flight at a time. req_ready is 0 from acceptance until the response. Each request produces one rsp_valid pulse lasting a single cycle.
- R10: With inj_valid=1 while the block is idle, stored bit inj_bit of line inj_idx in the active bank is inverted. The tag entry is chosen when inj_tag=1 and the data entry when inj_tag=0. The data entry holds bits [DATA_W-1:0] as data and the bits above them as byte parity. The tag entry holds tag bits [TAG_W-1:0], the valid bit at TAG_W and parity at TAG_W+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_we | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load result |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory access done, mem_rdata valid for reads |
| mem_rdata | input | DATA_W | Memory read data |
| thresh | input | CNT_W | Error count that selects the spare bank, 0 disables |
| clr_cnt | input | 1 | Clear error counter |
| err_count | output | CNT_W | Saturating parity error count |
| spare_on | output | 1 | Spare bank is active |
| inj_valid | input | 1 | Fault-injection strobe |
| inj_tag | input | 1 | Inject into tag entry (1) or data entry (0) |
| inj_idx | input | IDX_W | Line to corrupt |
| inj_bit | input | SEL_W | Bit position to invert |

## Verification
The hardest state to reach is the bank switch, because it needs a precise number of parity failures, and each failure needs a valid line whose stored bits have been corrupted in just the right way. The stimulus first warms lines through ordinary reads. It then inverts single data, parity or tag bits through the injection port and reads each line back. The thresh value is raised only after a first error has been counted with it at 0, so the disable case and the exact triggering count are both reached in one run. Once the switch is seen, a line that was cached before it is read again, which shows that the new bank starts out empty.

// File: rtl/pc_cache.sv
module pc_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4,
  localparam int BYTES = DATA_W / 8,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int TE_W  = TAG_W + 2,
  localparam int DE_W  = DATA_W + BYTES,
  localparam int SEL_W = $clog2(DE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CNT_W-1:0]  thresh,
  input  logic              clr_cnt,
  output logic [CNT_W-1:0]  err_count,
  output logic              spare_on,
  input  logic              inj_valid,
  input  logic              inj_tag,
  input  logic [IDX_W-1:0]  inj_idx,
  input  logic [SEL_W-1:0]  inj_bit
);
  localparam int LINES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL, S_WMEM} st_t;

  function automatic logic [BYTES-1:0] byte_par(input logic [DATA_W-1:0] d);
    logic [BYTES-1:0] p;
    for (int b = 0; b < BYTES; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  st_t               st;
  logic [ADDR_W-1:0] a_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic [TE_W-1:0]   te_q [2][LINES];
  logic [DE_W-1:0]   de_q [2][LINES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tg;
  logic [TE_W-1:0]  te;
  logic [DE_W-1:0]  de;
  logic tag_err, data_err, hit, bad, cnt_inc, swap;
  logic [CNT_W-1:0] cnt_nxt;

  assign idx      = a_q[IDX_W-1:0];
  assign tg       = a_q[ADDR_W-1:IDX_W];
  assign te       = te_q[spare_on][idx];
  assign de       = de_q[spare_on][idx];
  assign tag_err  = ^te;
  assign data_err = byte_par(de[DATA_W-1:0]) != de[DE_W-1:DATA_W];
  assign hit      = !tag_err && te[TAG_W] && (te[TAG_W-1:0] == tg);
  assign bad      = tag_err || (hit && !we_q && data_err);
  assign cnt_inc  = (st == S_LOOK) && bad && (err_count != CNT_MAX);
  assign cnt_nxt  = clr_cnt ? '0 : cnt_inc ? err_count + 1'b1 : err_count;
  assign swap     = !spare_on && cnt_inc && !clr_cnt && (thresh != '0) && (cnt_nxt == thresh);

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_FILL) || (st == S_WMEM);
  assign mem_we    = (st == S_WMEM);
  assign mem_addr  = a_q;
  assign mem_wdata = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      a_q       <= '0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_count <= '0;
      spare_on  <= 1'b0;
      for (int k = 0; k < LINES; k++) begin
        te_q[0][k] <= '0;
        te_q[1][k] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      err_count <= cnt_nxt;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            a_q  <= req_addr;
            we_q <= req_we;
            wd_q <= req_wdata;
            st   <= S_LOOK;
          end else if (inj_valid) begin
            if (inj_tag) te_q[spare_on][inj_idx] <= te_q[spare_on][inj_idx] ^ (TE_W'(1) << inj_bit);
            else         de_q[spare_on][inj_idx] <= de_q[spare_on][inj_idx] ^ (DE_W'(1) << inj_bit);
          end
        end
        S_LOOK: begin
          if (we_q) begin
            if (hit) de_q[spare_on][idx] <= {byte_par(wd_q), wd_q};
            if (tag_err) te_q[spare_on][idx] <= '0;
            st <= S_WMEM;
          end else if (hit && !data_err) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= de[DATA_W-1:0];
            st        <= S_IDLE;
          end else begin
            te_q[spare_on][idx] <= '0;
            st <= S_FILL;
          end
          if (swap) begin
            spare_on <= 1'b1;
            for (int k = 0; k < LINES; k++) te_q[1][k] <= '0;
          end
        end
        S_FILL: if (mem_ack) begin
          te_q[spare_on][idx] <= {^{1'b1, tg}, 1'b1, tg};
          de_q[spare_on][idx] <= {byte_par(mem_rdata), mem_rdata};
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_rdata;
          st        <= S_IDLE;
        end
        default: if (mem_ack) begin
          rsp_valid <= 1'b1;
          st        <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pc_cache_chk.sv
module pc_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  thresh,
  input logic              clr_cnt,
  input logic [CNT_W-1:0]  err_count,
  input logic              spare_on
);
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R9
  AST_BUSY_WHILE_MEM: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !req_ready); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3
  AST_SPARE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) spare_on |=> spare_on); // R6
  AST_SPARE_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spare_on) |-> (err_count == thresh && thresh != '0)); // R6
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) clr_cnt |=> err_count == '0); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cnt |=> (err_count == $past(err_count) || err_count == CNT_W'($past(err_count) + 1'b1))); // R8
endmodule

bind pc_cache pc_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .thresh(thresh),
  .clr_cnt(clr_cnt), .err_count(err_count), .spare_on(spare_on)
);

// File: tb/test_pc_cache.sv
module test_pc_cache;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [7:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic [3:0] thresh = 0, err_count;
  logic clr_cnt = 0, spare_on;
  logic inj_valid = 0, inj_tag = 0;
  logic [2:0] inj_idx = 0;
  logic [5:0] inj_bit = 0;

  pc_cache i_pc_cache (.*);

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] mem_m [256];
  logic [31:0] gold [256];
  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;

  // stimulus: {we, addr, wdata, expected memory reads}
  localparam logic [42:0] VEC [12] = '{
    {1'b0, 8'h10, 32'h0, 2'd1}, {1'b0, 8'h10, 32'h0, 2'd0},
    {1'b1, 8'h10, 32'hDEADBEEF, 2'd0}, {1'b0, 8'h10, 32'h0, 2'd0},
    {1'b0, 8'h18, 32'h0, 2'd1}, {1'b0, 8'h10, 32'h0, 2'd1},
    {1'b1, 8'h21, 32'h12345678, 2'd0}, {1'b0, 8'h21, 32'h0, 2'd1},
    {1'b0, 8'h21, 32'h0, 2'd0}, {1'b1, 8'hFF, 32'hCAFEF00D, 2'd0},
    {1'b0, 8'hFF, 32'h0, 2'd1}, {1'b0, 8'hFF, 32'h0, 2'd0}
  };

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_m[i] = {8'(i), ~8'(i), 8'(i) ^ 8'h5A, 8'hC3};
      gold[i]  = mem_m[i];
    end
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (mem_we) begin mem_m[mem_addr] = mem_wdata; n_wr++; end
        else begin mem_rdata = mem_m[mem_addr]; n_rd++; end
        mem_ack = 1;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata;
    if (we) gold[a] = d;
  endtask

  task automatic rd_chk(input string rq, input logic [7:0] a, input int exp_rd);
    int r0;
    logic [31:0] q;
    r0 = n_rd;
    access(1'b0, a, 32'h0, q);
    chk({rq, " data"}, q, gold[a]);
    chk({rq, " memory reads"}, 32'(n_rd - r0), 32'(exp_rd));
  endtask

  task automatic inject(input logic tg, input logic [2:0] ix, input logic [5:0] b);
    @(negedge clk);
    inj_valid = 1; inj_tag = tg; inj_idx = ix; inj_bit = b;
    @(negedge clk);
    inj_valid = 0;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [42:0] v;
    logic [31:0] q;
    int r0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 err_count", 32'(err_count), 0);
    chk("R1 spare_on", 32'(spare_on), 0);

    // R2 R3 table walk
    for (int i = 0; i < 12; i++) begin
      v = VEC[i];
      r0 = n_rd; w0 = n_wr;
      access(v[42], v[41:34], v[33:2], q);
      if (!v[42]) chk("R2 table data", q, gold[v[41:34]]);
      else chk("R3 table memory word", mem_m[v[41:34]], v[33:2]);
      chk("R2 table memory reads", 32'(n_rd - r0), 32'(v[1:0]));
      chk("R3 table memory writes", 32'(n_wr - w0), 32'(v[42]));
    end
    @(negedge clk);
    chk("R9 pulse ends", 32'(rsp_valid), 0);
    chk("R9 ready after response", 32'(req_ready), 1);

    // R4 data error with thresh 0 (R6 disabled)
    rd_chk("R10 warm line", 8'h10, 0);
    inject(1'b0, 3'd0, 6'd5);
    rd_chk("R4 data error refill", 8'h10, 1);
    chk("R4 count", 32'(err_count), 1);
    chk("R6 thresh zero no spare", 32'(spare_on), 0);
    rd_chk("R4 transient gone", 8'h10, 0);
    chk("R4 count stable", 32'(err_count), 1);

    // R5 tag error
    thresh = 3;
    inject(1'b1, 3'd0, 6'd2);
    rd_chk("R5 tag error refill", 8'h10, 1);
    chk("R5 count", 32'(err_count), 2);
    chk("R6 below thresh", 32'(spare_on), 0);

    // R6 parity-bit error reaches threshold
    inject(1'b0, 3'd0, 6'd33);
    rd_chk("R6 refill at switch", 8'h10, 1);
    chk("R6 count at thresh", 32'(err_count), 3);
    chk("R6 spare selected", 32'(spare_on), 1);
    rd_chk("R6 spare bank empty", 8'h21, 1);
    rd_chk("R6 spare bank fills", 8'h21, 0);

    // R7 clear
    @(negedge clk); clr_cnt = 1;
    @(negedge clk); clr_cnt = 0;
    chk("R7 cleared", 32'(err_count), 0);
    inject(1'b0, 3'd1, 6'd9);
    @(negedge clk); clr_cnt = 1;
    rd_chk("R7 error under clear", 8'h21, 1);
    @(negedge clk); clr_cnt = 0;
    chk("R7 clear beats increment", 32'(err_count), 0);
    chk("R6 spare persists", 32'(spare_on), 1);

    // R8 saturation
    rd_chk("R8 warm", 8'h22, 1);
    for (int k = 0; k < 16; k++) begin
      inject(1'b0, 3'd2, 6'(k));
      access(1'b0, 8'h22, 32'h0, q);
      chk("R8 data under errors", q, gold[8'h22]);
    end
    chk("R8 saturated", 32'(err_count), 15);

    // R3 write then read on spare bank
    r0 = n_wr;
    access(1'b1, 8'h22, 32'h0BADF00D, q);
    chk("R3 single write", 32'(n_wr - r0), 1);
    rd_chk("R3 write hit updates", 8'h22, 0);

    finish_up();
  end
endmodule